// File: doc/BRIEF.md
# Branch and Skip Next-PC Unit

This block works out where a small 8-bit core fetches next. It accepts one control-flow decision per issue strobe and covers these cases:

- ordinary sequential advance;
- a relative jump or relative call with a signed offset;
- a return or interrupt return served from a small private return-address stack;
- a conditional branch on one chosen status-register bit;
- a skip of the following instruction when a tested bit matches a chosen polarity.

For each decision it also reports how many cycles the instruction occupies, raises a push or pop pulse when the return stack moves, and flags the interrupt-enable set that an interrupt return carries.

The surrounding decoder supplies the operation code, the current PC, the raw offset field, the status byte, the flag index and the tested bit. For a skip, the decoder also says whether the instruction being skipped is one word or two. The decoder reduces register-bit tests, I/O-bit tests and compare-equal tests to a single tested bit before they reach the block. All results are registered and appear one clock after the issue strobe. Return addresses live in a fixed three-entry shift stack inside the block. A push when the stack is full drops the oldest entry, and a return with nothing stored yields address zero.

Top module: `bnp_next_pc`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, every output is zero.
- R2: An issue with op code 0 (sequential) gives next PC = PC + 1 with a cycle count of 1. All PC arithmetic wraps modulo 2^PC_W.
- R3: An issue with op code 1 (relative jump) gives next PC = PC + k + 1, where k is the full 12-bit offset taken as signed two's complement. The cycle count is 2.
- R4: An issue with op code 2 (relative call) gives the same target as R3 and a cycle count of 3. It pulses `push_o` and stores PC + 1 on the return stack.
- R5: An issue with op code 3 (return) or op code 4 (interrupt return) gives the most recently stored return address as next PC. Either one pulses `pop_o` and has a cycle count of 4. Only op code 4 also pulses `set_i_o`.
- R6: The return stack holds 3 addresses. A fourth push without a pop discards the oldest address. A return from an empty stack gives next PC = 0.
- R7: Op code 5 (branch if flag set) is taken when `sreg_i[bit_sel_i]` is 1. Op code 6 (branch if flag clear) is taken when that bit is 0. A taken branch gives PC + k + 1, with k = offset bits [6:0] as signed, and a cycle count of 2. A branch that is not taken gives PC + 1 and a cycle count of 1.
- R8: Op code 7 (skip) is taken when `test_bit_i` equals `skip_pol_i`. When taken, it gives PC + 2 with a cycle count of 2 if `next_long_i` is 0, and PC + 3 with a cycle count of 3 if `next_long_i` is 1. A skip that is not taken gives PC + 1 and a cycle count of 1.
- R9: Results appear on the clock after the issue. `done_o` is high for exactly that cycle. On a cycle with no issue, `done_o`, `push_o`, `pop_o` and `set_i_o` are low, while `next_pc_o` and `cycles_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | A control-flow decision is presented this cycle |
| op_i | input | 3 | Operation code (0 seq, 1 jump, 2 call, 3 ret, 4 reti, 5 br-set, 6 br-clear, 7 skip) |
| pc_i | input | PC_W | PC of the issuing instruction |
| ofs_i | input | JOFS_W | Raw signed offset field |
| sreg_i | input | 8 | Status register |
| bit_sel_i | input | 3 | Index of the status bit a branch tests |
| test_bit_i | input | 1 | Bit value tested by a skip |
| skip_pol_i | input | 1 | Value of the tested bit that makes a skip happen |
| next_long_i | input | 1 | The following instruction is two words long |
| next_pc_o | output | PC_W | Next fetch address |
| push_o | output | 1 | Return stack pushed |
| pop_o | output | 1 | Return stack popped |
| set_i_o | output | 1 | Interrupt-enable flag to be set |
| cycles_o | output | 3 | Cycles the instruction occupies |
| done_o | output | 1 | Outputs carry a new result |

## Verification
Most wrong state in this block shows up one clock after the faulty issue, as a bad `next_pc_o` or `cycles_o`. The return stack is the exception. A corrupted or mis-shifted entry stays hidden until the return that pops it, which can come many issues later. For that reason the stimulus nests calls deeper than the stack, interleaves other operations, and then unwinds past empty. A misplaced flag index or an inverted skip polarity only shows for some status patterns, so branches and skips are run against many status bytes and every bit index.

// File: rtl/bnp_pkg.sv
package bnp_pkg;
  typedef enum logic [2:0] {
    OP_SEQ   = 3'd0,
    OP_JMP   = 3'd1,
    OP_CALL  = 3'd2,
    OP_RET   = 3'd3,
    OP_RETI  = 3'd4,
    OP_BRSET = 3'd5,
    OP_BRCLR = 3'd6,
    OP_SKIP  = 3'd7
  } bnp_op_e;

  localparam int CYC_W = 3;
endpackage

// File: rtl/bnp_cond.sv
module bnp_cond #(
  parameter int FLAG_W = 8,
  parameter int SEL_W  = $clog2(FLAG_W)
) (
  input  bnp_pkg::bnp_op_e  op,
  input  logic [FLAG_W-1:0] flags,
  input  logic [SEL_W-1:0]  sel,
  input  logic              test_bit,
  input  logic              skip_pol,
  output logic              taken
);
  logic flag_bit;
  assign flag_bit = flags[sel];

  always_comb begin
    taken = 1'b0;
    case (op)
      bnp_pkg::OP_BRSET: taken = flag_bit;
      bnp_pkg::OP_BRCLR: taken = ~flag_bit;
      bnp_pkg::OP_SKIP:  taken = (test_bit == skip_pol);
      default:           taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/bnp_target.sv
module bnp_target #(
  parameter int PC_W   = 10,
  parameter int JOFS_W = 12,
  parameter int BOFS_W = 7
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [JOFS_W-1:0] ofs,
  output logic [PC_W-1:0]   pc_seq,
  output logic [PC_W-1:0]   pc_jump,
  output logic [PC_W-1:0]   pc_branch,
  output logic [PC_W-1:0]   pc_skip2,
  output logic [PC_W-1:0]   pc_skip3
);
  localparam int EXT_W = (PC_W > JOFS_W) ? PC_W : JOFS_W;

  logic [EXT_W-1:0] jext;
  logic [EXT_W-1:0] bext;

  assign jext = EXT_W'($signed(ofs));
  assign bext = EXT_W'($signed(ofs[BOFS_W-1:0]));

  assign pc_seq    = pc + PC_W'(1);
  assign pc_skip2  = pc + PC_W'(2);
  assign pc_skip3  = pc + PC_W'(3);
  assign pc_jump   = pc_seq + jext[PC_W-1:0];
  assign pc_branch = pc_seq + bext[PC_W-1:0];
endmodule

// File: rtl/bnp_retstack.sv
module bnp_retstack #(
  parameter int DEPTH = 3,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top
);
  logic [W-1:0] ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] from_above;
    logic [W-1:0] from_below;

    if (i == 0) begin : g_first
      assign from_above = push_data;
    end else begin : g_mid
      assign from_above = ent[i-1];
    end

    if (i == DEPTH - 1) begin : g_last
      assign from_below = '0;
    end else begin : g_inner
      assign from_below = ent[i+1];
    end

    always_ff @(posedge clk) begin
      if (rst)       ent[i] <= '0;
      else if (push) ent[i] <= from_above;
      else if (pop)  ent[i] <= from_below;
    end
  end

  assign top = ent[0];

  // R6
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));
endmodule

// File: rtl/bnp_next_pc.sv
module bnp_next_pc #(
  parameter int PC_W      = 10,
  parameter int JOFS_W    = 12,
  parameter int BOFS_W    = 7,
  parameter int STK_DEPTH = 3,
  parameter int FLAG_W    = 8,
  parameter int SEL_W     = $clog2(FLAG_W)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      issue_i,
  input  logic [2:0]                op_i,
  input  logic [PC_W-1:0]           pc_i,
  input  logic [JOFS_W-1:0]         ofs_i,
  input  logic [FLAG_W-1:0]         sreg_i,
  input  logic [SEL_W-1:0]          bit_sel_i,
  input  logic                      test_bit_i,
  input  logic                      skip_pol_i,
  input  logic                      next_long_i,
  output logic [PC_W-1:0]           next_pc_o,
  output logic                      push_o,
  output logic                      pop_o,
  output logic                      set_i_o,
  output logic [bnp_pkg::CYC_W-1:0] cycles_o,
  output logic                      done_o
);
  import bnp_pkg::*;

  bnp_op_e         op;
  logic [PC_W-1:0] pc_seq, pc_jump, pc_branch, pc_skip2, pc_skip3, ret_top;
  logic            taken;
  logic [PC_W-1:0] nx_pc;
  logic [CYC_W-1:0] nx_cyc;
  logic            nx_push, nx_pop, nx_seti;

  assign op = bnp_op_e'(op_i);

  bnp_target #(.PC_W(PC_W), .JOFS_W(JOFS_W), .BOFS_W(BOFS_W)) u_target (
    .pc(pc_i), .ofs(ofs_i), .pc_seq(pc_seq), .pc_jump(pc_jump),
    .pc_branch(pc_branch), .pc_skip2(pc_skip2), .pc_skip3(pc_skip3)
  );

  bnp_cond #(.FLAG_W(FLAG_W), .SEL_W(SEL_W)) u_cond (
    .op(op), .flags(sreg_i), .sel(bit_sel_i), .test_bit(test_bit_i),
    .skip_pol(skip_pol_i), .taken(taken)
  );

  bnp_retstack #(.DEPTH(STK_DEPTH), .W(PC_W)) u_stack (
    .clk(clk), .rst(rst), .push(issue_i && nx_push), .pop(issue_i && nx_pop),
    .push_data(pc_seq), .top(ret_top)
  );

  always_comb begin
    nx_pc   = pc_seq;
    nx_cyc  = CYC_W'(1);
    nx_push = 1'b0;
    nx_pop  = 1'b0;
    nx_seti = 1'b0;
    case (op)
      OP_JMP: begin
        nx_pc  = pc_jump;
        nx_cyc = CYC_W'(2);
      end
      OP_CALL: begin
        nx_pc   = pc_jump;
        nx_cyc  = CYC_W'(3);
        nx_push = 1'b1;
      end
      OP_RET, OP_RETI: begin
        nx_pc   = ret_top;
        nx_cyc  = CYC_W'(4);
        nx_pop  = 1'b1;
        nx_seti = (op == OP_RETI);
      end
      OP_BRSET, OP_BRCLR: begin
        if (taken) begin
          nx_pc  = pc_branch;
          nx_cyc = CYC_W'(2);
        end
      end
      OP_SKIP: begin
        if (taken) begin
          nx_pc  = next_long_i ? pc_skip3 : pc_skip2;
          nx_cyc = next_long_i ? CYC_W'(3) : CYC_W'(2);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc_o <= '0;
      cycles_o  <= '0;
      push_o    <= 1'b0;
      pop_o     <= 1'b0;
      set_i_o   <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o  <= issue_i;
      push_o  <= issue_i && nx_push;
      pop_o   <= issue_i && nx_pop;
      set_i_o <= issue_i && nx_seti;
      if (issue_i) begin
        next_pc_o <= nx_pc;
        cycles_o  <= nx_cyc;
      end
    end
  end

  // R4
  call_push_chk: assert property (@(posedge clk) disable iff (rst)
    issue_i && op_i == 3'd2 |=> push_o && !pop_o && cycles_o == 3'd3);

  // R5
  ret_pop_chk: assert property (@(posedge clk) disable iff (rst)
    issue_i && (op_i == 3'd3 || op_i == 3'd4) |=> pop_o && !push_o && cycles_o == 3'd4);

  // R5
  seti_with_pop_chk: assert property (@(posedge clk) disable iff (rst)
    set_i_o |-> pop_o && done_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !issue_i |=> !done_o && !push_o && !pop_o && !set_i_o && $stable(next_pc_o) && $stable(cycles_o));

  // R8
  skip_long_chk: assert property (@(posedge clk) disable iff (rst)
    issue_i && op_i == 3'd7 && test_bit_i == skip_pol_i && next_long_i
    |=> next_pc_o == $past(pc_i) + PC_W'(3));
endmodule

// File: tb/bnp_next_pc_tb_top.sv
module bnp_next_pc_tb_top;
  localparam int PC_W  = 10;
  localparam int JW    = 12;
  localparam int DEPTH = 3;
  localparam int MODV  = 1 << PC_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue = 1'b0;
  logic [2:0] op = '0;
  logic [PC_W-1:0] pc = '0;
  logic [JW-1:0] ofs = '0;
  logic [7:0] sreg = '0;
  logic [2:0] sel = '0;
  logic tbit = 1'b0, pol = 1'b0, nlong = 1'b0;
  logic [PC_W-1:0] next_pc;
  logic push, pop, seti, done;
  logic [2:0] cycles;

  int checks = 0;
  int fails = 0;
  int stk[$];
  int e_pc = 0, e_cyc = 0, e_push = 0, e_pop = 0, e_seti = 0, e_done = 0;
  int lcg = 12345;

  always #10 clk = ~clk;

  bnp_next_pc dut_i (
    .clk(clk), .rst(rst), .issue_i(issue), .op_i(op), .pc_i(pc), .ofs_i(ofs),
    .sreg_i(sreg), .bit_sel_i(sel), .test_bit_i(tbit), .skip_pol_i(pol),
    .next_long_i(nlong), .next_pc_o(next_pc), .push_o(push), .pop_o(pop),
    .set_i_o(seti), .cycles_o(cycles), .done_o(done)
  );

  function automatic int wrap(int v);
    return ((v % MODV) + MODV) % MODV;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (int'(next_pc) != e_pc || int'(cycles) != e_cyc || int'(push) != e_push ||
        int'(pop) != e_pop || int'(seti) != e_seti || int'(done) != e_done) begin
      fails++;
      $display("FAIL %s: got pc=%0d cyc=%0d push=%0d pop=%0d seti=%0d done=%0d, expected pc=%0d cyc=%0d push=%0d pop=%0d seti=%0d done=%0d",
               tag, next_pc, cycles, push, pop, seti, done,
               e_pc, e_cyc, e_push, e_pop, e_seti, e_done);
    end
  endtask

  // Reference model: one issue (or idle cycle) advanced behaviourally.
  task automatic model(int iss, int o, int p, int k, int sr, int s, int tb, int pl, int nl);
    int kj, kb, fl;
    e_push = 0; e_pop = 0; e_seti = 0; e_done = iss;
    if (iss == 0) return;
    kj = (k >= 2048) ? k - 4096 : k;
    kb = k % 128;
    if (kb >= 64) kb -= 128;
    fl = (sr >> s) & 1;
    e_pc = wrap(p + 1); e_cyc = 1;
    case (o)
      1: begin e_pc = wrap(p + kj + 1); e_cyc = 2; end
      2: begin
        e_pc = wrap(p + kj + 1); e_cyc = 3; e_push = 1;
        stk.push_front(wrap(p + 1));
        if (stk.size() > DEPTH) void'(stk.pop_back());
      end
      3, 4: begin
        e_pc = (stk.size() == 0) ? 0 : stk.pop_front();
        e_cyc = 4; e_pop = 1; e_seti = (o == 4);
      end
      5, 6: if ((o == 5 && fl == 1) || (o == 6 && fl == 0)) begin
        e_pc = wrap(p + kb + 1); e_cyc = 2;
      end
      7: if (tb == pl) begin
        e_pc = wrap(p + 2 + nl); e_cyc = 2 + nl;
      end
      default: ;
    endcase
  endtask

  task automatic step(int iss, int o, int p, int k, int sr, int s, int tb, int pl, int nl, string tag);
    issue = iss[0]; op = o[2:0]; pc = p[PC_W-1:0]; ofs = k[JW-1:0];
    sreg = sr[7:0]; sel = s[2:0]; tbit = tb[0]; pol = pl[0]; nlong = nl[0];
    @(posedge clk);
    model(iss, o, p, k, sr, s, tb, pl, nl);
    @(negedge clk);
    compare(tag);
  endtask

  function automatic int rnd();
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    return lcg >>> 8;
  endfunction

  function automatic string tag_of(int iss, int o);
    if (iss == 0) return "R9";
    case (o)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4: return "R5";
      5, 6: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state, while asserted and just after release
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R6: return from an empty stack gives 0
    step(1, 3, 100, 0, 0, 0, 0, 0, 0, "R6");
    // R2: sequential advance, including wrap
    step(1, 0, 5, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 0, MODV - 1, 0, 0, 0, 0, 0, 0, "R2");
    // R3: forward, backward, wrapping jumps
    step(1, 1, 10, 20, 0, 0, 0, 0, 0, "R3");
    step(1, 1, 10, 4096 - 5, 0, 0, 0, 0, 0, "R3");
    step(1, 1, 3, 4096 - 2048, 0, 0, 0, 0, 0, "R3");
    step(1, 1, 1000, 2047, 0, 0, 0, 0, 0, "R3");
    // R9: idle cycles hold
    step(0, 1, 77, 77, 0, 0, 0, 0, 0, "R9");
    step(0, 2, 77, 77, 0, 0, 0, 0, 0, "R9");
    // R4/R6: four calls overflow the 3-deep stack
    step(1, 2, 100, 50, 0, 0, 0, 0, 0, "R4");
    step(1, 2, 200, 4090, 0, 0, 0, 0, 0, "R4");
    step(1, 1, 300, 3, 0, 0, 0, 0, 0, "R3");
    step(1, 2, 300, 7, 0, 0, 0, 0, 0, "R4");
    step(1, 2, 400, 7, 0, 0, 0, 0, 0, "R6");
    // R5/R6: unwind past empty, with an interrupt return
    step(1, 3, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    step(1, 4, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(1, 3, 0, 0, 0, 0, 0, 0, 0, "R6");
    step(1, 4, 0, 0, 0, 0, 0, 0, 0, "R6");
    // R7: every bit index, both polarities, branch offset uses 7 bits
    for (int b = 0; b < 8; b++) begin
      step(1, 5, 500, 4096 - 10, 1 << b, b, 0, 0, 0, "R7");
      step(1, 5, 500, 4096 - 10, 8'hff ^ (1 << b), b, 0, 0, 0, "R7");
      step(1, 6, 500, 12'h83F, 8'hff ^ (1 << b), b, 0, 0, 0, "R7");
      step(1, 6, 500, 12'h83F, 1 << b, b, 0, 0, 0, "R7");
    end
    step(1, 5, 2, 12'h0C0, 8'h01, 0, 0, 0, 0, "R7");
    // R8: skip taken (short/long) and not taken
    for (int t = 0; t < 8; t++)
      step(1, 7, 700, 0, 0, 0, t & 1, (t >> 1) & 1, (t >> 2) & 1, "R8");
    step(1, 7, MODV - 2, 0, 0, 0, 1, 1, 1, "R8");
    // mixed pseudo-random traffic
    for (int n = 0; n < 400; n++) begin
      int iss, o;
      iss = (rnd() % 5 != 0);
      o = rnd() % 8;
      step(iss, o, rnd() % MODV, rnd() % 4096, rnd() % 256, rnd() % 8,
           rnd() % 2, rnd() % 2, rnd() % 2, tag_of(iss, o));
    end
    // R1: reset mid-run clears outputs and stack
    step(1, 2, 123, 5, 0, 0, 0, 0, 0, "R4");
    rst = 1'b1;
    @(posedge clk);
    stk.delete();
    e_pc = 0; e_cyc = 0; e_push = 0; e_pop = 0; e_seti = 0; e_done = 0;
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
    step(1, 3, 9, 0, 0, 0, 0, 0, 0, "R6");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule